// File: doc/BRIEF.md
# Asynchronous Frame Transmitter

This block turns data words into asynchronous serial frames on a single output line. A producer writes a word into a one-entry holding buffer. When transmission is permitted, the word moves into a shift register, and the line carries a start bit, the data bits, an optional parity bit and one or two stop bits. Each bit lasts a fixed number of ticks of an oversampling strobe, and a baud generator outside the block supplies that strobe.

Several settings shape each frame: the data length, the parity mode, the stop count, the bit order and the inversion of the data bits. These settings are captured when a frame starts. A separate line-polarity control inverts the whole waveform, idle level included. An optional clear-to-send input gates the start of each frame. A single-cycle interrupt pulse marks one of two moments, chosen by configuration: the buffer handing its word to the shift register, or the end of the final stop bit.

Top module: `async_tx`

## Requirements
- R1: After reset, `txd` is high, `buf_empty` is 1 and `irq` is 0.
- R2: A frame is a 0 start bit, then N data bits, an optional parity bit, and then 1 stop bit (`cfg_stop2`=0) or 2 stop bits (`cfg_stop2`=1), all stop bits at 1. N is 7, 8 or 9 for `cfg_len` = 0, 1 or 2, and 9 for `cfg_len` = 3. Each bit lasts OVS ticks.
- R3: With `cfg_par_en`=1, the parity bit makes the count of ones among the transmitted data bits plus parity even (`cfg_par_odd`=0) or odd (`cfg_par_odd`=1).
- R4: `cfg_msb_first`=0 sends data bit 0 first. `cfg_msb_first`=1 sends data bit N-1 first.
- R5: `cfg_data_inv`=1 inverts every data bit on the line, and parity is computed over the inverted bits. The start and stop bits are unchanged.
- R6: `cfg_line_inv`=1 inverts the whole line, so the idle level becomes low and the start and stop bits are inverted too.
- R7: A frame starts only when `tx_en` is 1, the buffer holds a word, and either `cfg_cts_use` is 0 or `cts_n` is 0.
- R8: `cts_n` is considered only when a frame is about to start. Raising it during a frame does not shorten or alter that frame.
- R9: A write sets `buf_empty` to 0. The start of a frame sets it back to 1, unless a write arrives in the same cycle. A word written during a frame is sent as the next frame.
- R10: With `cfg_irq_on_done`=0, `irq` pulses for one cycle, in the first cycle the start bit is on the line.
- R11: With `cfg_irq_on_done`=1, `irq` pulses for one cycle, in the first cycle after the final stop bit ends, which is frame-length × OVS ticks after the start.
- R12: Bit timing advances only on cycles with `tick` high. While `tick` is low the line holds its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Oversampling strobe, OVS per bit |
| tx_en | input | 1 | Transmit enable |
| wr_valid | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 9 | Word to send (low N bits used) |
| cts_n | input | 1 | Clear to send, active low |
| cfg_cts_use | input | 1 | 1: gate frame start on `cts_n` |
| cfg_len | input | 2 | Data length select (0:7, 1:8, 2/3:9) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even |
| cfg_stop2 | input | 1 | 1: two stop bits |
| cfg_msb_first | input | 1 | 1: highest data bit first |
| cfg_data_inv | input | 1 | Invert data bits only |
| cfg_line_inv | input | 1 | Invert entire line |
| cfg_irq_on_done | input | 1 | 1: interrupt at frame end, 0: at buffer hand-off |
| txd | output | 1 | Serial line |
| buf_empty | output | 1 | Holding buffer has no word |
| irq | output | 1 | Single-cycle interrupt pulse |

## Verification
The bench builds the block with OVS = 4 and holds the tick high most of the time. A bit then lasts four cycles and the longest frame about fifty, which makes a full sweep affordable. The sweep covers every combination of the three lengths, three parity modes, two stop counts, two bit orders, both inversions and both interrupt points, each with two data words. Directed runs then check that the tick stalls bit timing, and that the enable and clear-to-send gates hold a loaded word back. They also raise clear-to-send mid-frame and queue a word while a frame is on the line.

// File: rtl/async_tx_pkg.sv
// Shared constants, configuration types and helpers for the frame transmitter.
// Assumes a data word of at most DATA_MAX bits and a frame of at most
// 1 start + DATA_MAX data + 1 parity + 2 stop bits.
package async_tx_pkg;

    localparam int DATA_MAX  = 9;
    localparam int FRAME_MAX = 1 + DATA_MAX + 1 + 2;
    localparam int CNT_W     = $clog2(FRAME_MAX + 1);

    typedef enum logic [1:0] {
        LEN_7  = 2'd0,
        LEN_8  = 2'd1,
        LEN_9  = 2'd2,
        LEN_9X = 2'd3
    } len_sel_e;

    typedef struct packed {
        len_sel_e len;
        logic     par_en;
        logic     par_odd;
        logic     stop2;
        logic     msb_first;
        logic     data_inv;
    } frame_cfg_t;

    // Number of data bits for a length code.
    function automatic int len_bits(len_sel_e sel);
        case (sel)
            LEN_7:   return 7;
            LEN_8:   return 8;
            default: return 9;
        endcase
    endfunction

endpackage

// File: rtl/async_tx_buf.sv
// One-entry holding buffer in front of the shift register.
// Assumes a write wins over a take in the same cycle, so a word written while
// the previous word is being taken stays pending.
module async_tx_buf
    import async_tx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_valid,
    input  logic [DATA_MAX-1:0] wr_data,
    input  logic                take,
    output logic                full,
    output logic [DATA_MAX-1:0] data
);

    // Holds the occupancy flag: a write sets it, a take clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
        end else if (wr_valid) begin
            full <= 1'b1;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    // Stores the written word; needs no reset because the flag guards it.
    always_ff @(posedge clk) begin
        if (wr_valid) begin
            data <= wr_data;
        end
    end

endmodule

// File: rtl/async_tx_framer.sv
// Combinational frame builder. It turns a data word and a frame configuration
// into a bit vector in line order, where bit 0 is sent first, together with the
// count of valid bits. Bits above the count read 1, so stop bits and any padding
// stay at the mark level. Line polarity is not applied here.
module async_tx_framer
    import async_tx_pkg::*;
(
    input  logic [DATA_MAX-1:0]  data,
    input  frame_cfg_t           cfg,
    output logic [FRAME_MAX-1:0] frame,
    output logic [CNT_W-1:0]     nbits
);

    logic [DATA_MAX-1:0] flipped;
    logic [DATA_MAX-1:0] masked;
    logic [DATA_MAX-1:0] ordered;
    logic                par_bit;
    logic [3:0]          src_idx;
    int                  n_data;

    // Applies the data-only inversion to each bit position.
    for (genvar g = 0; g < DATA_MAX; g++) begin : g_flip
        assign flipped[g] = data[g] ^ cfg.data_inv;
    end

    // Masks unused bits, reorders the rest, computes parity and assembles the frame.
    always_comb begin
        n_data  = len_bits(cfg.len);
        masked  = '0;
        ordered = '0;
        src_idx = '0;
        for (int i = 0; i < DATA_MAX; i++) begin
            if (i < n_data) begin
                masked[i] = flipped[i];
            end
        end
        for (int i = 0; i < DATA_MAX; i++) begin
            if (i < n_data) begin
                src_idx    = cfg.msb_first ? 4'(n_data - 1 - i) : 4'(i);
                ordered[i] = masked[src_idx];
            end
        end
        par_bit  = (^masked) ^ cfg.par_odd;
        frame    = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DATA_MAX; i++) begin
            if (i < n_data) begin
                frame[1 + i] = ordered[i];
            end
        end
        if (cfg.par_en) begin
            frame[4'(1 + n_data)] = par_bit;
        end
        nbits = CNT_W'(1 + n_data + (cfg.par_en ? 1 : 0) + (cfg.stop2 ? 2 : 1));
    end

endmodule

// File: rtl/async_tx_shifter.sv
// Bit timer and output shift register. It loads a frame vector and a bit count,
// then sends one bit every OVS ticks, least significant position first. The
// done pulse marks the tick that ends the last bit. Assumes load is raised only
// while the shifter is idle.
module async_tx_shifter
    import async_tx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 load,
    input  logic [FRAME_MAX-1:0] frame_in,
    input  logic [CNT_W-1:0]     nbits_in,
    output logic                 busy,
    output logic                 line,
    output logic                 done
);

    localparam int TW = (OVS > 1) ? $clog2(OVS) : 1;
    localparam logic [TW-1:0] T_LAST = TW'(OVS - 1);

    logic [FRAME_MAX-1:0] sreg;
    logic [CNT_W-1:0]     left;
    logic [TW-1:0]        tcnt;
    logic                 bit_end;

    assign bit_end = busy && tick && (tcnt == T_LAST);
    assign done    = bit_end && (left == CNT_W'(1));
    assign line    = busy ? sreg[0] : 1'b1;

    // Loads a frame, then counts ticks and shifts one bit per OVS ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            sreg <= '1;
            left <= '0;
            tcnt <= '0;
        end else if (load) begin
            busy <= 1'b1;
            sreg <= frame_in;
            left <= nbits_in;
            tcnt <= '0;
        end else if (busy && tick) begin
            if (bit_end) begin
                tcnt <= '0;
                sreg <= {1'b1, sreg[FRAME_MAX-1:1]};
                left <= left - CNT_W'(1);
                if (left == CNT_W'(1)) begin
                    busy <= 1'b0;
                end
            end else begin
                tcnt <= tcnt + TW'(1);
            end
        end
    end

endmodule

// File: rtl/async_tx.sv
// Top of the frame transmitter. It connects the holding buffer, frame builder
// and shifter, applies the start gate (enable, pending word, clear-to-send),
// registers the interrupt pulse and applies line polarity at the output.
// Frame shape settings are sampled at the start of a frame. Line polarity acts
// at once.
module async_tx
    import async_tx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                tx_en,
    input  logic                wr_valid,
    input  logic [DATA_MAX-1:0] wr_data,
    input  logic                cts_n,
    input  logic                cfg_cts_use,
    input  logic [1:0]          cfg_len,
    input  logic                cfg_par_en,
    input  logic                cfg_par_odd,
    input  logic                cfg_stop2,
    input  logic                cfg_msb_first,
    input  logic                cfg_data_inv,
    input  logic                cfg_line_inv,
    input  logic                cfg_irq_on_done,
    output logic                txd,
    output logic                buf_empty,
    output logic                irq
);

    logic                 full;
    logic [DATA_MAX-1:0]  held;
    logic                 load;
    logic                 busy;
    logic                 line;
    logic                 done;
    logic [FRAME_MAX-1:0] frame;
    logic [CNT_W-1:0]     nbits;
    frame_cfg_t           fcfg;
    logic                 irq_q;

    assign fcfg = '{len:       len_sel_e'(cfg_len),
                    par_en:    cfg_par_en,
                    par_odd:   cfg_par_odd,
                    stop2:     cfg_stop2,
                    msb_first: cfg_msb_first,
                    data_inv:  cfg_data_inv};

    assign load      = !busy && tx_en && full && (!cfg_cts_use || !cts_n);
    assign buf_empty = !full;
    assign txd       = line ^ cfg_line_inv;
    assign irq       = irq_q;

    async_tx_buf u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .take     (load),
        .full     (full),
        .data     (held)
    );

    async_tx_framer u_framer (
        .data  (held),
        .cfg   (fcfg),
        .frame (frame),
        .nbits (nbits)
    );

    async_tx_shifter #(.OVS(OVS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (load),
        .frame_in (frame),
        .nbits_in (nbits),
        .busy     (busy),
        .line     (line),
        .done     (done)
    );

    // Registers the interrupt at the hand-off or at the end of the frame, per mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= cfg_irq_on_done ? done : load;
        end
    end

endmodule

// File: rtl/async_tx_chk.sv
// Property checker for the frame transmitter, attached to every instance of
// the top by the bind below. It watches the ports and the shifter busy flag.
module async_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic tx_en,
    input logic wr_valid,
    input logic cts_n,
    input logic cfg_cts_use,
    input logic cfg_line_inv,
    input logic cfg_irq_on_done,
    input logic busy,
    input logic txd,
    input logic buf_empty,
    input logic irq
);

    // R6 (and R1): an idle line rests at the mark level, inverted by line polarity.
    a_r6_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (txd == !cfg_line_inv));

    // R2: the first bit of every frame is a space.
    a_r2_start_space: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) && $stable(cfg_line_inv) |-> (txd == cfg_line_inv));

    // R7: a frame begins only with enable, a pending word and clearance.
    a_r7_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(tx_en) && !$past(buf_empty)
                        && (!$past(cfg_cts_use) || !$past(cts_n)));

    // R9: the start of a frame empties the buffer unless a write coincides.
    a_r9_take_empties: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) && !$past(wr_valid) |-> buf_empty);

    // R10: hand-off mode pulses the interrupt with the start bit.
    a_r10_irq_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) && !$past(cfg_irq_on_done) |-> irq);

    // R11: completion mode pulses the interrupt when the frame ends.
    a_r11_irq_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) && $past(cfg_irq_on_done) |-> irq);

    // R12: without a tick the line does not move during a frame.
    a_r12_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) && busy && !$past(tick) && $stable(cfg_line_inv) |-> $stable(txd));

endmodule

bind async_tx async_tx_chk u_async_tx_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .tick            (tick),
    .tx_en           (tx_en),
    .wr_valid        (wr_valid),
    .cts_n           (cts_n),
    .cfg_cts_use     (cfg_cts_use),
    .cfg_line_inv    (cfg_line_inv),
    .cfg_irq_on_done (cfg_irq_on_done),
    .busy            (busy),
    .txd             (txd),
    .buf_empty       (buf_empty),
    .irq             (irq)
);

// File: tb/test_async_tx.sv
// Self-checking bench: a configuration sweep plus directed gate, timing and
// queueing cases. Expected frames are computed arithmetically from the settings.
module test_async_tx;

    localparam int OVS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       tx_en = 1'b1;
    logic       wr_valid = 1'b0;
    logic [8:0] wr_data = '0;
    logic       cts_n = 1'b0;
    logic       cfg_cts_use = 1'b0;
    logic [1:0] cfg_len = 2'd1;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_stop2 = 1'b0;
    logic       cfg_msb_first = 1'b0;
    logic       cfg_data_inv = 1'b0;
    logic       cfg_line_inv = 1'b0;
    logic       cfg_irq_on_done = 1'b0;
    logic       txd;
    logic       buf_empty;
    logic       irq;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    async_tx #(.OVS(OVS)) i_async_tx (
        .clk             (clk),
        .rst_n           (rst_n),
        .tick            (tick),
        .tx_en           (tx_en),
        .wr_valid        (wr_valid),
        .wr_data         (wr_data),
        .cts_n           (cts_n),
        .cfg_cts_use     (cfg_cts_use),
        .cfg_len         (cfg_len),
        .cfg_par_en      (cfg_par_en),
        .cfg_par_odd     (cfg_par_odd),
        .cfg_stop2       (cfg_stop2),
        .cfg_msb_first   (cfg_msb_first),
        .cfg_data_inv    (cfg_data_inv),
        .cfg_line_inv    (cfg_line_inv),
        .cfg_irq_on_done (cfg_irq_on_done),
        .txd             (txd),
        .buf_empty       (buf_empty),
        .irq             (irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int data_len();
        return (cfg_len == 2'd0) ? 7 : (cfg_len == 2'd1) ? 8 : 9;
    endfunction

    function automatic int frame_len();
        return 1 + data_len() + int'(cfg_par_en) + 1 + int'(cfg_stop2);
    endfunction

    // Expected frame in line order without polarity: bit 0 is the start bit.
    function automatic logic [12:0] exp_frame(input logic [8:0] d);
        logic [12:0] f;
        logic        p;
        logic        b;
        int          n;
        f = '1;
        f[0] = 1'b0;
        p = cfg_par_odd;
        n = data_len();
        for (int i = 0; i < n; i++) begin
            b = d[cfg_msb_first ? (n - 1 - i) : i] ^ cfg_data_inv;
            p = p ^ b;
            f[1 + i] = b;
        end
        if (cfg_par_en) f[1 + n] = p;
        return f;
    endfunction

    task automatic write_buf(input logic [8:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    // Waits for a start bit, samples mid-bit and checks bits, interrupt and idle.
    task automatic capture_frame(input logic [8:0] d, input string tag);
        int          nb;
        int          t;
        int          irq_cnt;
        int          irq_at;
        int          exp_irq;
        logic [12:0] expf;
        logic [12:0] got;
        logic [12:0] mask;
        logic        idle;
        nb      = frame_len();
        expf    = exp_frame(d);
        got     = '1;
        idle    = ~cfg_line_inv;
        t       = 0;
        irq_cnt = 0;
        irq_at  = -1;
        while (txd == idle && t < 300) begin
            @(negedge clk);
            t++;
        end
        if (t >= 300) begin
            chk(1'b0, tag, 0, 1);
            return;
        end
        for (int c = 0; c <= nb * OVS + 1; c++) begin
            if (c == 0) chk(buf_empty == 1'b1, "R9", int'(buf_empty), 1);
            if (irq) begin
                irq_cnt++;
                if (irq_at < 0) irq_at = c;
            end
            if ((c % OVS) == OVS / 2 && (c / OVS) < nb) got[c / OVS] = txd ^ cfg_line_inv;
            if (c == nb * OVS + 1) chk(txd == idle, "R6", int'(txd), int'(idle));
            if (c < nb * OVS + 1) @(negedge clk);
        end
        mask = 13'((14'd1 << nb) - 14'd1);
        chk((got & mask) == (expf & mask), tag, int'(got & mask), int'(expf & mask));
        exp_irq = cfg_irq_on_done ? nb * OVS : 0;
        chk(irq_cnt == 1 && irq_at == exp_irq, cfg_irq_on_done ? "R11" : "R10",
            irq_at, exp_irq);
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [8:0] words [2];
        int         t;
        int         bad;
        int         nb;
        logic       v;
        string      tag;
        words[0] = 9'h1A5;
        words[1] = 9'h04B;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(txd == 1'b1, "R1", int'(txd), 1);
        chk(buf_empty == 1'b1, "R1", int'(buf_empty), 1);
        chk(irq == 1'b0, "R1", int'(irq), 0);

        // Sweep of every frame configuration with both interrupt points.
        for (int l = 0; l < 3; l++)
        for (int p = 0; p < 3; p++)
        for (int s = 0; s < 2; s++)
        for (int m = 0; m < 2; m++)
        for (int di = 0; di < 2; di++)
        for (int li = 0; li < 2; li++)
        for (int im = 0; im < 2; im++)
        for (int w = 0; w < 2; w++) begin
            @(negedge clk);
            cfg_len         = 2'(l);
            cfg_par_en      = (p != 0);
            cfg_par_odd     = (p == 2);
            cfg_stop2       = s[0];
            cfg_msb_first   = m[0];
            cfg_data_inv    = di[0];
            cfg_line_inv    = li[0];
            cfg_irq_on_done = im[0];
            @(negedge clk);
            if (li != 0)      tag = "R6";
            else if (di != 0) tag = "R5";
            else if (m != 0)  tag = "R4";
            else if (p != 0)  tag = "R3";
            else              tag = "R2";
            write_buf(words[w]);
            capture_frame(words[w], tag);
        end

        // Reset-like defaults for the directed cases.
        @(negedge clk);
        cfg_len = 2'd1; cfg_par_en = 1'b1; cfg_par_odd = 1'b0; cfg_stop2 = 1'b0;
        cfg_msb_first = 1'b0; cfg_data_inv = 1'b0; cfg_line_inv = 1'b0;
        cfg_irq_on_done = 1'b1;

        // R7: disabled transmitter holds the word.
        tx_en = 1'b0;
        write_buf(9'h0C3);
        bad = 0;
        repeat (40) begin
            @(negedge clk);
            if (txd !== 1'b1 || buf_empty !== 1'b0) bad++;
        end
        chk(bad == 0, "R7", bad, 0);
        tx_en = 1'b1;
        capture_frame(9'h0C3, "R7");

        // R7: clear-to-send high blocks the start while gating is on.
        cfg_cts_use = 1'b1;
        cts_n = 1'b1;
        write_buf(9'h03C);
        bad = 0;
        repeat (40) begin
            @(negedge clk);
            if (txd !== 1'b1 || buf_empty !== 1'b0) bad++;
        end
        chk(bad == 0, "R7", bad, 0);
        cts_n = 1'b0;
        capture_frame(9'h03C, "R7");

        // R8: raising clear-to-send mid-frame does not disturb the frame.
        write_buf(9'h096);
        fork
            capture_frame(9'h096, "R8");
            begin
                repeat (10) @(negedge clk);
                cts_n = 1'b1;
            end
        join

        // R7: with gating off, a high clear-to-send is ignored.
        cfg_cts_use = 1'b0;
        write_buf(9'h0E1);
        capture_frame(9'h0E1, "R7");
        cts_n = 1'b0;

        // R9: a word queued during a frame waits, then follows.
        write_buf(9'h011);
        repeat (6) @(negedge clk);
        write_buf(9'h0EE);
        chk(buf_empty == 1'b0, "R9", int'(buf_empty), 0);
        t = 0;
        while (!irq && t < 200) begin
            @(negedge clk);
            t++;
        end
        @(negedge clk);
        capture_frame(9'h0EE, "R9");

        // R12: stalled tick freezes the line and stretches the frame.
        nb = frame_len();
        write_buf(9'h055);
        t = 0;
        while (txd == 1'b1 && t < 300) begin
            @(negedge clk);
            t++;
        end
        repeat (6) @(negedge clk);
        tick = 1'b0;
        v = txd;
        bad = 0;
        repeat (20) begin
            @(negedge clk);
            if (txd !== v) bad++;
        end
        chk(bad == 0, "R12", bad, 0);
        tick = 1'b1;
        t = 26;
        while (!irq && t < 400) begin
            @(negedge clk);
            t++;
        end
        chk(t == nb * OVS + 20, "R12", t, nb * OVS + 20);

        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule